// File: doc/BRIEF.md
# Transposed-Form FIR Equalizer

This block is an eight-tap finite impulse response equalizer built in transposed form. Each accepted input sample is broadcast to all tap multipliers at once. The products are summed through a chain of partial-sum registers, so the logic between any two registers is one multiply followed by one add, whatever the tap count. The input and the output streams both use valid/ready handshakes, and a small write port loads the coefficient bank.

An accepted sample produces one output word on the next cycle. That word equals the direct-form convolution of the accepted samples with the coefficients. Cycles with no transfer leave the filter state unchanged, so gaps in the stream do not insert zeros. Back-pressure rule: when the output holds a word that has not been taken (`out_valid` high and `out_ready` low), `in_ready` drops and the word stays steady. The bench's reference model is a direct-form convolution over accepted samples.

Top module: `fir_xpose_eq`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every partial sum is zero. Samples before the first accepted sample count as zero.
- R2: With fixed coefficients, the output word for the n-th accepted sample is the sum over k = 0..7 of c[k]·x[n-k], using signed samples and signed coefficients.
- R3: The output is computed at full precision, with no wrap. The extreme case of eight samples of -32 times coefficients of -128 yields +32768 on the 17-bit signed output.
- R4: `out_valid` rises in the cycle after a transfer on the input (`in_valid` and `in_ready` both high). It falls after a transfer on the output if no new input transfer occurred in that cycle.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold and `in_ready` is 0.
- R6: A cycle with no input transfer changes neither `out_data` nor the filter state. The next output continues the convolution as if the idle cycle had not occurred.
- R7: When `coef_we` is 1, `coef_data` is written to coefficient `coef_idx`, where index 0 weights the newest sample. A sample transferred in that same cycle still uses the old value.
- R8: When coefficients change mid-stream, the term c[k]·x[n-k] uses the value of c[k] that was in force when x[n-k] was transferred.
- R9: `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | 6 | Signed input sample |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 17 | Signed filter output |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 3 | Coefficient index (0 = newest sample) |
| coef_data | input | 8 | Signed coefficient value |

## Verification
Two events can land in the same cycle: a coefficient write and an input transfer. A further overlap is an output stall and an offered input. The random phase writes coefficients in about one cycle out of eight, independent of the input and output handshake patterns, and adds directed cycles that write a tap exactly as a sample enters. The direct-form model records each sample's products with the coefficients in force on its arrival. It then judges every output word, and every `in_ready` value, against that history.

// File: rtl/fir_xpose_pkg.sv
package fir_xpose_pkg;
  localparam int DEF_TAPS = 8;
  localparam int DEF_X_W  = 6;
  localparam int DEF_C_W  = 8;

  // Growth of a sum of n products: ceil(log2(n)) extra bits.
  function automatic int sum_growth(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int TAPS  = 8,
  parameter int C_W   = 8,
  parameter int IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          idx,
  input  logic [C_W-1:0]            wdata,
  output logic [TAPS-1:0][C_W-1:0]  coef
);
  for (genvar k = 0; k < TAPS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        coef[k] <= '0;
      else if (we && (idx == IDX_W'(k)))
        coef[k] <= wdata;
    end
  end
endmodule

// File: rtl/fir_tap_cell.sv
module fir_tap_cell #(
  parameter int X_W = 6,
  parameter int C_W = 8,
  parameter int A_W = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [X_W-1:0] x,
  input  logic signed [C_W-1:0] c,
  input  logic signed [A_W-1:0] sin,
  output logic signed [A_W-1:0] sout
);
  logic signed [A_W-1:0] xe, ce, prod;

  always_comb begin
    xe   = A_W'(x);
    ce   = A_W'(c);
    prod = xe * ce;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sout <= '0;
    else if (en)
      sout <= prod + sin;
  end
endmodule

// File: rtl/fir_xpose_eq.sv
module fir_xpose_eq
  import fir_xpose_pkg::*;
#(
  parameter int TAPS = DEF_TAPS,
  parameter int X_W  = DEF_X_W,
  parameter int C_W  = DEF_C_W,
  localparam int IDX_W = (TAPS <= 1) ? 1 : $clog2(TAPS),
  localparam int A_W   = X_W + C_W + sum_growth(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [X_W-1:0]   in_sample,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [A_W-1:0]   out_data,
  input  logic             coef_we,
  input  logic [IDX_W-1:0] coef_idx,
  input  logic [C_W-1:0]   coef_data
);
  logic [TAPS-1:0][C_W-1:0] coef;
  logic signed [A_W-1:0]    part [TAPS+1];
  logic                     take;

  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;
  assign part[TAPS] = '0;
  assign out_data   = part[0];

  fir_coef_bank #(.TAPS(TAPS), .C_W(C_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .idx(coef_idx),
    .wdata(coef_data), .coef(coef)
  );

  // Cell k adds c[k]*x to the partial sum from cell k+1; cell 0 feeds the output.
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    fir_tap_cell #(.X_W(X_W), .C_W(C_W), .A_W(A_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .en(take),
      .x(in_sample), .c(coef[k]),
      .sin(part[k+1]), .sout(part[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else if (take)
      out_valid <= 1'b1;
    else if (out_ready)
      out_valid <= 1'b0;
  end
endmodule

// File: rtl/fir_xpose_eq_chk.sv
module fir_xpose_eq_chk #(
  parameter int A_W = 17
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [A_W-1:0] out_data
);
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_idle_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_valid_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && out_ready) |=> !out_valid);

  assert_idle_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_data));
endmodule

bind fir_xpose_eq fir_xpose_eq_chk #(.A_W(A_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/fir_xpose_eq_tb.sv
module fir_xpose_eq_tb;
  localparam int TAPS = 8;
  localparam int X_W = 6;
  localparam int C_W = 8;
  localparam int A_W = 17;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, coef_we = 0;
  logic in_ready, out_valid;
  logic [X_W-1:0] in_sample = '0;
  logic [A_W-1:0] out_data;
  logic [2:0] coef_idx = '0;
  logic [C_W-1:0] coef_data = '0;

  int total = 0, bad = 0;
  int m_a [TAPS];
  int hist [TAPS][TAPS];
  int m_y = 0;
  bit m_ov = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fir_xpose_eq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_data(coef_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w-1))) ? v - (1 << w) : v;
  endfunction

  // One cycle: drive at negedge, predict, check 1 ns after the posedge.
  task automatic step(input string tag, input bit iv, input int x, input bit ordy,
                      input bit we, input int idx, input int cd);
    bit er, acc;
    @(negedge clk);
    in_valid = iv; in_sample = X_W'(x); out_ready = ordy;
    coef_we = we; coef_idx = 3'(idx); coef_data = C_W'(cd);
    #1;
    er = !m_ov || ordy;
    check("R9", int'(in_ready), int'(er));
    acc = iv && er;
    if (acc) begin
      for (int i = TAPS-1; i > 0; i--)
        for (int j = 0; j < TAPS; j++) hist[i][j] = hist[i-1][j];
      for (int j = 0; j < TAPS; j++) hist[0][j] = m_a[j] * x;
      m_y = 0;
      for (int k = 0; k < TAPS; k++) m_y += hist[k][k];
      m_ov = 1;
    end else if (ordy) m_ov = 0;
    if (we) m_a[idx] = cd;
    @(posedge clk); #1;
    check("R4", int'(out_valid), int'(m_ov));
    if (m_ov) check(tag, sx(int'(out_data), A_W), m_y);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int xs;
    process::self().srandom(32'd1234);
    for (int i = 0; i < TAPS; i++) begin
      m_a[i] = 0;
      for (int j = 0; j < TAPS; j++) hist[i][j] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(out_valid), 0);
    check("R1", int'(in_ready), 1);
    rst_n = 1;
    // R7: load coefficients 1..8 (index 0 = newest sample weight)
    for (int k = 0; k < TAPS; k++) step("R7", 0, 0, 1, 1, k, k + 1);
    // R1/R2: impulse from zero state walks out the coefficients
    step("R1", 1, 1, 1, 0, 0, 0);
    for (int k = 1; k < TAPS + 2; k++) step("R2", 1, 0, 1, 0, 0, 0);
    // R6: gaps between samples add no zeros
    step("R6", 1, 5, 1, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0, 0);
    step("R6", 1, -3, 1, 0, 0, 0);
    // R5: stall holds data and blocks input
    step("R5", 1, 7, 0, 0, 0, 0);
    step("R5", 1, 9, 0, 0, 0, 0);
    step("R5", 1, 11, 0, 0, 0, 0);
    step("R5", 1, 13, 1, 0, 0, 0);
    // R7: write and transfer in the same cycle use the old coefficient
    step("R7", 1, 10, 1, 1, 0, -50);
    step("R7", 1, 4, 1, 0, 0, 0);
    // R3: extreme magnitudes, no wrap
    for (int k = 0; k < TAPS; k++) step("R3", 0, 0, 1, 1, k, -128);
    for (int k = 0; k < TAPS; k++) step("R3", 1, -32, 1, 0, 0, 0);
    check("R3", sx(int'(out_data), A_W), 32768);
    for (int k = 0; k < TAPS; k++) step("R3", 1, 31, 1, 0, 0, 0);
    // R8: random stream with coefficient writes mid-flight
    for (int n = 0; n < 3000; n++) begin
      xs = int'($urandom_range(0, 63)) - 32;
      step(($urandom_range(0, 1) == 0) ? "R8" : "R2",
           $urandom_range(0, 3) != 0, xs, $urandom_range(0, 3) != 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 7),
           int'($urandom_range(0, 255)) - 128);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule